// File: doc/BRIEF.md
# Lockable Pin Configuration Register Bank

This block holds one 32-bit configuration word for each pin of a port. Each word carries a pull direction, a pull enable, a slow-slew select, a passive input filter enable, an open-drain enable, a high-drive select, a 3-bit function select, a sticky lock bit and a 4-bit interrupt mode. The fields drive the pad logic directly through per-pin output vectors. A status flag, produced by interrupt logic outside the block, is shown read-only in each word.

Software reaches the bank over a simple word-addressed register bus with byte strobes. Reads are combinational. Two write-only broadcast words follow the pin words. Each broadcast word copies one data halfword into the lower halfword of any chosen subset of a group of 16 pin words. A pin that has been locked keeps its lower halfword until reset. A broadcast skips a locked pin and still updates the other selected pins. The interrupt mode stays writable after a lock, so the interrupt setup can be changed while the pad setup is frozen.

Top module: `pincfg_bank`

## Requirements
- R1: After reset every pin word reads 0x00000742 (function select 7, drive high, pull enabled, pull down, unlocked) with interrupt mode 0.
- R2: A write to byte address 4*n (n = 0..31) updates pin word n. Byte strobe 0 covers bits 7:0, strobe 1 covers bits 15:8 and strobe 2 covers bits 19:16. Only bits 0,1,2,4,5,6,10:8,15 and 19:16 are stored. Bits 3, 7, 14:11, 23:20 and 31:25 always read as zero.
- R3: Once bit 15 (lock) of a pin word is 1, bits 15:0 of that word ignore every direct and broadcast write, including writes that try to clear the lock. Only reset clears the lock.
- R4: Bits 19:16 (interrupt mode) of a locked pin word still take direct writes.
- R5: A full-strobe write to 0x80 takes data in bits 15:0 and a mask in bits 31:16. Each pin k in 0..15 whose mask bit 16+k is 1 gets its stored lower-halfword bits replaced by the data. Unselected pins keep their value.
- R6: A full-strobe write to 0x84 does the same for pins 16..31, with mask bit 16+k selecting pin 16+k.
- R7: A broadcast leaves locked target pins unchanged and still updates the unlocked targets in the same write.
- R8: A write to 0x80 or 0x84 with any byte strobe clear changes no pin word. Both broadcast addresses always read as zero.
- R9: The pad outputs of pin n always equal the fields stored in pin word n. The analog indication is 1 exactly when function select is 000; value 001 is general-purpose I/O.
- R10: Bit 24 of pin word n reads the pin_flag[n] input, and writes to bit 24 do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write byte address |
| wr_be | input | 4 | Write byte strobes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| pin_flag | input | 32 | Per-pin status flag from interrupt logic |
| pad_pull_sel | output | 32 | Pull direction, 1 = up |
| pad_pull_en | output | 32 | Pull enable |
| pad_slew_slow | output | 32 | Slow slew select |
| pad_pfilt_en | output | 32 | Passive filter enable |
| pad_odrain | output | 32 | Open-drain enable |
| pad_drive_hi | output | 32 | High drive select |
| pad_func | output | 96 | Function select, 3 bits per pin |
| pad_analog | output | 32 | Pin in analog (disabled) function |
| pad_irq_mode | output | 128 | Interrupt mode, 4 bits per pin |
| pad_locked | output | 32 | Lock state per pin |

## Verification
The bench locks a pin and then tries to clear the lock with a direct write and with a broadcast. A design that let either write through would read back an unlocked word. In the same broadcast an unlocked neighbour must still update, so a design that aborted the whole broadcast at the first locked target would be caught. The bench also writes the interrupt mode after locking, which catches a lock that covers too many bits, and it sends a partial-strobe broadcast, which a design that ignores the strobes would apply. Broadcasts with sparse masks in both groups check that the mask bits are mapped to the right pins, and a second reset confirms that the lock is released.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;
  localparam int GRP = 16;
  localparam logic [15:0] LO_WMASK = 16'h8777;
  localparam logic [15:0] LO_RESET = 16'h0742;
  localparam int LOCK_BIT = 15;
  localparam logic [31:0] RSVD_MASK = 32'hFEF0_7888;

  // Assemble the visible word from its stored parts.
  function automatic logic [31:0] pack_word(input logic [15:0] lo, input logic [3:0] mode,
                                            input logic flag);
    return {7'd0, flag, 4'd0, mode, lo};
  endfunction

  // Byte-strobed merge into the lower halfword, dropping unstored bits.
  function automatic logic [15:0] merge_lo(input logic [15:0] old, input logic [15:0] data,
                                           input logic [1:0] be);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}} & LO_WMASK;
    return (old & ~m) | (data & m);
  endfunction
endpackage

// File: rtl/pincfg_decode.sv
module pincfg_decode
  import pincfg_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [GRP-1:0]    bc_mask,
  output logic [NPINS-1:0]  dir_we,
  output logic [NPINS/GRP-1:0] grp_hit,
  output logic [NPINS-1:0]  bc_we
);
  localparam int NGROUPS = NPINS / GRP;
  localparam int WIDX_W  = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  assign aligned = (wr_addr[1:0] == 2'b00);
  assign widx    = wr_addr[ADDR_W-1:2];

  for (genvar p = 0; p < NPINS; p++) begin : g_dir
    assign dir_we[p] = wr_en && aligned && (widx == WIDX_W'(p));
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    assign grp_hit[g] = wr_en && aligned && (widx == WIDX_W'(NPINS + g)) && (wr_be == 4'hF);
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_bc
    assign bc_we[p] = grp_hit[p / GRP] && bc_mask[p % GRP];
  end

  always_comb begin
    // R2: a direct write lands on at most one pin word
    a_r2_one_target: assert ($onehot0(dir_we));
    // R5/R6: a write is either direct or broadcast, never both
    a_r5_no_mix: assert (!((|dir_we) && (|bc_we)));
    // R8: partial strobes never start a broadcast
    if (wr_be != 4'hF) a_r8_partial_bcast: assert (bc_we == '0);
  end
endmodule

// File: rtl/pincfg_reg.sv
module pincfg_reg
  import pincfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir_we,
  input  logic [2:0]  dir_be,
  input  logic [19:0] dir_data,
  input  logic        bc_we,
  input  logic [15:0] bc_data,
  output logic [15:0] lo_q,
  output logic [3:0]  mode_q,
  output logic        locked
);
  logic lo_dir_upd, lo_bc_upd;
  assign locked     = lo_q[LOCK_BIT];
  assign lo_dir_upd = dir_we && !locked && (dir_be[1:0] != 2'b00);
  assign lo_bc_upd  = bc_we && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= LO_RESET;
      mode_q <= 4'd0;
    end else begin
      if (lo_dir_upd)     lo_q <= merge_lo(lo_q, dir_data[15:0], dir_be[1:0]);
      else if (lo_bc_upd) lo_q <= merge_lo(lo_q, bc_data, 2'b11);
      if (dir_we && dir_be[2]) mode_q <= dir_data[19:16];
    end
  end

  // R3: a locked lower halfword never moves
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(lo_q));
  // R4: interrupt mode follows a strobed write even when locked
  a_r4_mode_free: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_be[2]) |=> (mode_q == $past(dir_data[19:16])));
  // R7: an unlocked broadcast target takes the data
  a_r7_bc_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_we && !locked) |=> (lo_q == ($past(bc_data) & LO_WMASK)));
endmodule

// File: rtl/pincfg_bank.sv
module pincfg_bank
  import pincfg_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic [NPINS-1:0]     pin_flag,
  output logic [NPINS-1:0]     pad_pull_sel,
  output logic [NPINS-1:0]     pad_pull_en,
  output logic [NPINS-1:0]     pad_slew_slow,
  output logic [NPINS-1:0]     pad_pfilt_en,
  output logic [NPINS-1:0]     pad_odrain,
  output logic [NPINS-1:0]     pad_drive_hi,
  output logic [NPINS*3-1:0]   pad_func,
  output logic [NPINS-1:0]     pad_analog,
  output logic [NPINS*4-1:0]   pad_irq_mode,
  output logic [NPINS-1:0]     pad_locked
);
  localparam int NGROUPS = NPINS / GRP;
  localparam int WIDX_W  = ADDR_W - 2;

  logic [NPINS-1:0]   dir_we, bc_we;
  logic [NGROUPS-1:0] grp_hit;
  logic [15:0]        lo_q   [NPINS];
  logic [3:0]         mode_q [NPINS];

  pincfg_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .bc_mask(wr_data[31:16]),
    .dir_we(dir_we), .grp_hit(grp_hit), .bc_we(bc_we)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pincfg_reg u_reg (
      .clk(clk), .rst_n(rst_n),
      .dir_we(dir_we[p]), .dir_be(wr_be[2:0]), .dir_data(wr_data[19:0]),
      .bc_we(bc_we[p]), .bc_data(wr_data[15:0]),
      .lo_q(lo_q[p]), .mode_q(mode_q[p]), .locked(pad_locked[p])
    );
    assign pad_pull_sel[p]     = lo_q[p][0];
    assign pad_pull_en[p]      = lo_q[p][1];
    assign pad_slew_slow[p]    = lo_q[p][2];
    assign pad_pfilt_en[p]     = lo_q[p][4];
    assign pad_odrain[p]       = lo_q[p][5];
    assign pad_drive_hi[p]     = lo_q[p][6];
    assign pad_func[p*3 +: 3]  = lo_q[p][10:8];
    assign pad_analog[p]       = (lo_q[p][10:8] == 3'b000);
    assign pad_irq_mode[p*4 +: 4] = mode_q[p];
  end

  logic [WIDX_W-1:0] ridx;
  assign ridx = rd_addr[ADDR_W-1:2];

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (rd_addr[1:0] == 2'b00 && ridx == WIDX_W'(p))
        rd_data = pack_word(lo_q[p], mode_q[p], pin_flag[p]);
    end
  end

  // R2: reserved bit positions never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD_MASK) == 32'd0);
  // R8: broadcast words read as zero
  a_r8_bcast_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[1:0] == 2'b00 && ridx >= WIDX_W'(NPINS)) |-> (rd_data == 32'd0));
endmodule

// File: tb/pincfg_bank_tb.sv
module pincfg_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam logic [15:0] WM = 16'h8777;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [NP-1:0] pin_flag = 0;
  logic [NP-1:0] pad_pull_sel, pad_pull_en, pad_slew_slow, pad_pfilt_en, pad_odrain;
  logic [NP-1:0] pad_drive_hi, pad_analog, pad_locked;
  logic [NP*3-1:0] pad_func;
  logic [NP*4-1:0] pad_irq_mode;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_lo [NP];
  logic [3:0]  m_mode [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pincfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pin_flag(pin_flag),
    .pad_pull_sel(pad_pull_sel), .pad_pull_en(pad_pull_en), .pad_slew_slow(pad_slew_slow),
    .pad_pfilt_en(pad_pfilt_en), .pad_odrain(pad_odrain), .pad_drive_hi(pad_drive_hi),
    .pad_func(pad_func), .pad_analog(pad_analog), .pad_irq_mode(pad_irq_mode),
    .pad_locked(pad_locked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_lo[p] = 16'h0742; m_mode[p] = 4'd0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // Drive one write and update the bench's own model of the bank.
  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    int w;
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
    w = a / 4;
    if (a[1:0] != 0) return;
    if (w < NP) begin
      if (be[2]) m_mode[w] = d[19:16];
      if (!m_lo[w][15]) begin
        if (be[0]) m_lo[w][7:0]  = d[7:0]  & WM[7:0];
        if (be[1]) m_lo[w][15:8] = d[15:8] & WM[15:8];
      end
    end else if (w < NP + 2 && be == 4'hF) begin
      for (int k = 0; k < 16; k++) begin
        int p;
        p = (w - NP) * 16 + k;
        if (d[16+k] && !m_lo[p][15]) m_lo[p] = d[15:0] & WM;
      end
    end
  endtask

  task automatic check_pin(input string req, input int p);
    logic [31:0] exp;
    rd_addr = 8'(p * 4); #1;
    exp = {7'd0, pin_flag[p], 4'd0, m_mode[p], m_lo[p]};
    check(req, rd_data, exp);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) check_pin(req, p);
  endtask

  task automatic t_reset();
    check_all("R1 reset word");
    check("R1 pad func pin5", {29'd0, pad_func[15 +: 3]}, 32'd7);
    check("R1 locked", pad_locked, 32'd0);
  endtask

  task automatic t_direct();
    bus_write(8'h0C, 4'hF, 32'hFFF0_7575);  // pin 3, lock bit clear
    check_pin("R2 full write pin3", 3);
    bus_write(8'h10, 4'b0001, 32'h000F_FF2D);  // pin 4, only byte 0
    check_pin("R2 byte0 only pin4", 4);
    bus_write(8'h14, 4'b0100, 32'h0009_0000);  // pin 5, only mode
    check_pin("R2 mode only pin5", 5);
    check_all("R2 no side effects");
  endtask

  task automatic t_bcast_low();
    bus_write(8'h80, 4'hF, 32'h00A5_0123);  // pins 0,2,5,7
    check_all("R5 low broadcast");
  endtask

  task automatic t_bcast_high();
    bus_write(8'h84, 4'hF, 32'h8001_0451);  // pins 16,31
    check_all("R6 high broadcast");
  endtask

  task automatic t_lock();
    bus_write(8'h1C, 4'hF, 32'h0000_8001);  // lock pin 7
    check("R3 lock visible", {31'd0, pad_locked[7]}, 32'd1);
    bus_write(8'h1C, 4'hF, 32'h0005_0742);  // try to unlock, set mode 5
    check_pin("R3 direct write blocked", 7);
    check("R4 mode after lock", {28'd0, pad_irq_mode[28 +: 4]}, 32'd5);
    bus_write(8'h80, 4'hF, 32'h0180_0002);  // pins 7 and 8
    check_pin("R7 locked target kept", 7);
    check_pin("R7 unlocked neighbour updated", 8);
  endtask

  task automatic t_partial_bcast();
    bus_write(8'h80, 4'b0111, 32'hFFFF_0000);
    bus_write(8'h84, 4'b1110, 32'hFFFF_0000);
    check_all("R8 partial broadcast ignored");
    rd_addr = 8'h80; #1; check("R8 read 0x80", rd_data, 32'd0);
    rd_addr = 8'h84; #1; check("R8 read 0x84", rd_data, 32'd0);
  endtask

  task automatic t_pads();
    bus_write(8'h30, 4'hF, 32'h0000_0077);  // pin 12, function 000
    check("R9 analog pin12", {31'd0, pad_analog[12]}, 32'd1);
    check("R9 pulls pin12", {30'd0, pad_pull_en[12], pad_pull_sel[12]}, 32'd3);
    check("R9 slew/filter/od/drive pin12",
          {28'd0, pad_slew_slow[12], pad_pfilt_en[12], pad_odrain[12], pad_drive_hi[12]}, 32'hF);
    check("R9 gpio pin2 func", {29'd0, pad_func[6 +: 3]}, 32'd1);
    check("R9 gpio pin2 not analog", {31'd0, pad_analog[2]}, 32'd0);
  endtask

  task automatic t_flag();
    pin_flag = 32'h0000_0200;
    bus_write(8'h24, 4'b1000, 32'h0000_0000);
    check_pin("R10 flag pin9", 9);
    check_pin("R10 no flag pin10", 10);
    pin_flag = 0;
  endtask

  task automatic t_reset_again();
    do_reset();
    check_all("R3 reset clears lock");
    bus_write(8'h1C, 4'hF, 32'h0000_0011);
    check_pin("R3 writable after reset", 7);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_bcast_low();
    t_bcast_high();
    t_lock();
    t_partial_bcast();
    t_pads();
    t_flag();
    t_reset_again();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule